// File: doc/BRIEF.md
# Byte-Serial Peripheral Port with Error Flags

This block is a byte-wide SPI peripheral that sits on a simple CPU register bus and talks to one serial partner over SCK, MOSI, MISO and an active-low select. As a master it generates SCK from the module clock at one of four rates and shifts a byte out on MOSI while sampling MISO. As a slave it follows an external SCK whenever the select is low. One fixed clock mode is used: SCK idles low, both sides sample on the rising edge, data changes on the falling edge, and the most significant bit goes first.

Software writes bytes into a transmit holding register that feeds the shift register, so a second byte can be queued while the first is on the wire. Received bytes land in a one-deep receive register. Two error flags report problems. Overflow means a byte arrived before the previous one was read. Mode fault means the select pin was at the wrong level. Each error flag clears only through a fixed two-access sequence that starts with a status read. A transmit-empty flag can raise an interrupt request.

Register map (bus_addr): 0 = control, 1 = status/setup, 2 = data. Control bits: [0] enable, [1] master, [2] transmit-empty interrupt enable. Status/setup bits: [7] receive full, [6] overflow, [5] mode fault, [4] mode-fault enable, [3] transmit empty, [2] reads 0, [1:0] rate code. Only bits [4] and [1:0] of status/setup are writable.

Top module: `spi_port`

## Requirements
- R1: After reset, status/setup reads 0x08 (transmit empty set, all other flags and the rate code clear), control reads 0x00, sck_out is 0 and irq is 0.
- R2: In master mode a byte written to the data register goes out MSB first on mosi_out, stable at each rising SCK edge. The 8 bits sampled from miso_in on the rising edges appear in the data register, and receive full (status bit 7) is set.
- R3: Writing the data register clears transmit empty (status bit 3). The flag sets again when the byte moves into the shift register. A byte queued during a transfer is sent right after it, with no software action.
- R4: irq is high exactly when transmit empty, the interrupt enable (control bit 2) and the enable (control bit 0) are all set.
- R5: In master mode, rate codes 0, 1, 2 and 3 (status bits [1:0]) give an SCK period of 4, 16, 64 and 256 module clocks, that is, twice the divisor 2, 8, 32 or 128.
- R6: When a byte completes while receive full is set, overflow (status bit 6) sets. The data register keeps the older byte, and the new byte is dropped.
- R7: Overflow clears only when a data read follows a status read that saw the flag set. A data read alone leaves it set.
- R8: In master mode with mode-fault enable (status bit 4) set, a low ss_n sets mode fault (status bit 5). With the enable clear, a master ignores ss_n and transfers normally.
- R9: In slave mode with mode-fault enable set, ss_n rising in the middle of a byte sets mode fault, and ss_n toggling with no transfer in progress does not. With the enable clear, no flag is raised, the aborted byte is discarded, and the next full byte is received normally.
- R10: Mode fault clears only when a control write follows a status read that saw the flag set. Clearing the mode-fault enable, or a control write with no such status read before it, leaves the flag set.
- R11: In slave mode the rate code has no effect. The slave shifts mosi_in in on rising sck_in edges and presents the queued byte MSB first on miso_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status/setup, 2 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Transmit-empty interrupt request |
| sck_in | input | 1 | Serial clock from an external master (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| mosi_in | input | 1 | Serial data in (slave mode) |
| mosi_out | output | 1 | Serial data out (master mode) |
| miso_in | input | 1 | Serial data in (master mode) |
| miso_out | output | 1 | Serial data out (slave mode) |
| ss_n | input | 1 | Active-low select; slave enable and master fault input |

## Verification
The hardest case to reach from the ports is a mode-fault flag that must survive several accesses before the clearing sequence is allowed to remove it. Any status read that saw the flag would arm the clear early. The stimulus therefore raises the fault, turns the enable off and issues a control write, all without reading status. The first status read then shows the flag has survived, and the armed control write that follows clears it. Overflow is produced by queuing a second byte during a master transfer, so two bytes complete back to back with no read between them.

// File: rtl/spi_port.sv
module spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       sck_in,
  output logic       sck_out,
  input  logic       mosi_in,
  output logic       mosi_out,
  input  logic       miso_in,
  output logic       miso_out,
  input  logic       ss_n
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic       ctl_en, ctl_mstr, ctl_tie;
  logic       mf_en;
  logic [1:0] rate;
  logic       rx_full, ovf, mfault, tx_empty;
  logic       ovf_arm, mf_arm;
  logic [7:0] tx_buf, rx_data, shreg;
  logic       samp, busy, sck_q, s_active;
  logic [2:0] bcnt;
  logic [6:0] div_cnt, div_lim;
  logic [2:0] sck_s;
  logic [1:0] mosi_s, ss_s;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire rd_stat = bus_rd && bus_addr == A_STAT;
  wire rd_data = bus_rd && bus_addr == A_DATA;

  wire is_m = ctl_en && ctl_mstr;
  wire is_s = ctl_en && !ctl_mstr;

  always_comb begin
    case (rate)
      2'd0:    div_lim = 7'd1;
      2'd1:    div_lim = 7'd7;
      2'd2:    div_lim = 7'd31;
      default: div_lim = 7'd127;
    endcase
  end

  wire tick   = busy && div_cnt == div_lim;
  wire s_rise = !ss_s[1] && sck_s[1] && !sck_s[2];
  wire s_fall = !ss_s[1] && !sck_s[1] && sck_s[2];
  wire rise   = is_m ? (tick && !sck_q) : (is_s && s_rise);
  wire fall   = is_m ? (tick && sck_q) : (is_s && s_fall);
  wire last   = fall && bcnt == 3'd7;
  wire [7:0] new_byte = {shreg[6:0], samp};

  wire load = !tx_empty && ((is_m && !busy) || (is_s && !s_active));

  wire ovf_set = last && rx_full && !rd_data;
  wire mf_set  = ctl_en && mf_en && (ctl_mstr ? !ss_s[1] : (s_active && ss_s[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      ss_s   <= 2'b11;
    end else begin
      sck_s  <= {sck_s[1:0], sck_in};
      mosi_s <= {mosi_s[0], mosi_in};
      ss_s   <= {ss_s[0], ss_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      samp     <= 1'b0;
      busy     <= 1'b0;
      sck_q    <= 1'b0;
      div_cnt  <= '0;
      bcnt     <= '0;
      s_active <= 1'b0;
    end else if (!ctl_en) begin
      busy     <= 1'b0;
      sck_q    <= 1'b0;
      div_cnt  <= '0;
      bcnt     <= '0;
      s_active <= 1'b0;
    end else begin
      if (load) begin
        shreg <= tx_buf;
        if (is_m) begin
          busy    <= 1'b1;
          div_cnt <= '0;
          sck_q   <= 1'b0;
        end
      end
      if (is_m && busy) begin
        if (tick) begin
          div_cnt <= '0;
          sck_q   <= !sck_q;
        end else begin
          div_cnt <= div_cnt + 7'd1;
        end
      end
      if (rise) samp <= is_m ? miso_in : mosi_s[1];
      if (fall) begin
        shreg <= new_byte;
        bcnt  <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          busy     <= 1'b0;
          s_active <= 1'b0;
        end
      end
      if (!is_m) begin
        busy  <= 1'b0;
        sck_q <= 1'b0;
      end
      if (is_s) begin
        if (ss_s[1]) begin
          s_active <= 1'b0;
          bcnt     <= '0;
        end else if (s_rise) begin
          s_active <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_mstr <= 1'b0;
      ctl_tie  <= 1'b0;
      mf_en    <= 1'b0;
      rate     <= 2'd0;
      tx_buf   <= '0;
      tx_empty <= 1'b1;
      rx_data  <= '0;
      rx_full  <= 1'b0;
      ovf      <= 1'b0;
      ovf_arm  <= 1'b0;
      mfault   <= 1'b0;
      mf_arm   <= 1'b0;
    end else begin
      if (wr_ctrl) {ctl_tie, ctl_mstr, ctl_en} <= bus_wdata[2:0];
      if (wr_stat) begin
        mf_en <= bus_wdata[4];
        rate  <= bus_wdata[1:0];
      end

      if (wr_data) begin
        tx_buf   <= bus_wdata;
        tx_empty <= 1'b0;
      end else if (load) begin
        tx_empty <= 1'b1;
      end

      if (last && (!rx_full || rd_data)) begin
        rx_data <= new_byte;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end

      if (ovf_set) ovf <= 1'b1;
      else if (rd_data && ovf_arm) ovf <= 1'b0;
      if (rd_stat) ovf_arm <= ovf;
      else if (rd_data) ovf_arm <= 1'b0;

      if (mf_set) mfault <= 1'b1;
      else if (wr_ctrl && mf_arm) mfault <= 1'b0;
      if (rd_stat) mf_arm <= mfault;
      else if (wr_ctrl) mf_arm <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {5'd0, ctl_tie, ctl_mstr, ctl_en};
      A_STAT:  bus_rdata = {rx_full, ovf, mfault, mf_en, tx_empty, 1'b0, rate};
      A_DATA:  bus_rdata = rx_data;
      default: bus_rdata = 8'd0;
    endcase
  end

  assign irq      = tx_empty && ctl_tie && ctl_en;
  assign sck_out  = sck_q;
  assign mosi_out = is_m && shreg[7];
  assign miso_out = is_s && !ss_s[1] && shreg[7];

  a_r6_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $stable(rx_data));

  a_r7_ovf_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(rd_data));

  a_r10_mf_clear_by_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mfault) |-> $past(wr_ctrl && mf_arm));

  a_r8_mf_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mfault) |-> $past(mf_en && ctl_en));

  a_r5_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_q);

  a_r3_txe_on_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(ctl_en));

endmodule

// File: tb/spi_port_tb.sv
module spi_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, sck_out, mosi_out, miso_out;
  logic       sck_in = 1'b0, mosi_in = 1'b0, ss_n = 1'b1;
  logic       miso_in;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [15:0] pat = '0;
  int          nfall = 0, base = 0;
  logic [15:0] got16 = '0;
  longint      t_prev = 0, t_last = 0;

  always #10 clk = ~clk;

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_in(sck_in), .sck_out(sck_out), .mosi_in(mosi_in), .mosi_out(mosi_out),
    .miso_in(miso_in), .miso_out(miso_out), .ss_n(ss_n)
  );

  assign miso_in = pat[15 - ((nfall - base) & 15)];
  always @(negedge sck_out) nfall <= nfall + 1;
  always @(posedge sck_out) begin
    got16  <= {got16[14:0], mosi_out};
    t_prev <= t_last;
    t_last <= $time;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pat(input logic [15:0] p);
    pat  = p;
    base = nfall;
  endtask

  task automatic slave_xfer(input logic [7:0] b, input int nbits, output logic [7:0] seen);
    seen = '0;
    ss_n = 1'b0;
    idle(4);
    for (int i = 0; i < nbits; i++) begin
      mosi_in = b[7-i];
      idle(6);
      sck_in = 1'b1;
      seen = {seen[6:0], miso_out};
      idle(6);
      sck_in = 1'b0;
    end
    idle(6);
    ss_n = 1'b1;
    idle(6);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd1, v); chk("R1 status", v, 8'h08);
    rd(2'd0, v); chk("R1 control", v, 8'h00);
    chk("R1 sck idle", sck_out, 1'b0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_master_basic;
    logic [7:0] v;
    wr(2'd0, 8'h03);
    set_pat(16'h3C00);
    wr(2'd2, 8'hA5);
    idle(60);
    chk("R2 mosi byte", got16[7:0], 8'hA5);
    rd(2'd1, v); chk("R2 status", v, 8'h88);
    rd(2'd2, v); chk("R2 rx byte", v, 8'h3C);
  endtask

  task automatic t_double_and_overflow;
    logic [7:0] v;
    wr(2'd0, 8'h06);
    chk("R4 irq gated by enable", irq, 1'b0);
    set_pat(16'h71E4);
    wr(2'd2, 8'h5B);
    rd(2'd1, v); chk("R3 tx empty cleared", v, 8'h00);
    wr(2'd0, 8'h07);
    idle(3);
    chk("R4 irq after handoff", irq, 1'b1);
    wr(2'd2, 8'hC6);
    chk("R4 irq low when queued", irq, 1'b0);
    rd(2'd1, v); chk("R3 queued not empty", v[3], 1'b0);
    idle(100);
    chk("R3 back to back bytes", got16, 16'h5BC6);
    rd(2'd2, v); chk("R6 old byte kept", v, 8'h71);
    rd(2'd1, v); chk("R7 data read alone keeps ovf", v, 8'h48);
    rd(2'd2, v);
    rd(2'd1, v); chk("R7 ovf cleared by sequence", v, 8'h08);
    wr(2'd0, 8'h03);
  endtask

  task automatic t_rates;
    logic [7:0] v;
    for (int r = 0; r < 4; r++) begin
      int bd;
      bd = 2 << (2 * r);
      wr(2'd1, 8'(r));
      set_pat(16'h0000);
      wr(2'd2, 8'h00);
      idle(16 * bd + 20);
      chk("R5 sck period", 16'((t_last - t_prev) / 20), 16'(2 * bd));
      rd(2'd2, v);
    end
    wr(2'd1, 8'h00);
  endtask

  task automatic t_master_fault;
    logic [7:0] v;
    ss_n = 1'b0;
    set_pat(16'h5A00);
    wr(2'd2, 8'h11);
    idle(60);
    rd(2'd1, v); chk("R8 ignore ss when disabled", v, 8'h88);
    rd(2'd2, v); chk("R8 transfer with ss low", v, 8'h5A);
    wr(2'd1, 8'h10);
    idle(4);
    wr(2'd1, 8'h00);
    ss_n = 1'b1;
    idle(4);
    wr(2'd0, 8'h03);
    rd(2'd1, v); chk("R10 flag survives", v, 8'h28);
    wr(2'd0, 8'h03);
    rd(2'd1, v); chk("R10 cleared by sequence", v, 8'h08);
  endtask

  task automatic t_slave;
    logic [7:0] v, seen;
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h96);
    idle(3);
    rd(2'd1, v); chk("R11 slave load", v, 8'h0B);
    slave_xfer(8'hC3, 8, seen);
    chk("R11 miso byte", seen, 8'h96);
    rd(2'd1, v); chk("R11 rx full", v, 8'h8B);
    rd(2'd2, v); chk("R11 rx byte", v, 8'hC3);
  endtask

  task automatic t_slave_fault;
    logic [7:0] v, seen;
    wr(2'd1, 8'h10);
    slave_xfer(8'hFF, 4, seen);
    rd(2'd1, v); chk("R9 fault on early ss rise", v, 8'h38);
    wr(2'd0, 8'h01);
    ss_n = 1'b0; idle(6); ss_n = 1'b1; idle(6);
    rd(2'd1, v); chk("R9 no fault when idle", v, 8'h18);
    wr(2'd1, 8'h00);
    slave_xfer(8'hFF, 4, seen);
    rd(2'd1, v); chk("R9 no fault when disabled", v, 8'h08);
    slave_xfer(8'h5E, 8, seen);
    rd(2'd2, v); chk("R9 normal byte after abort", v, 8'h5E);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_master_basic();
    t_double_and_overflow();
    t_rates();
    t_master_fault();
    t_slave();
    t_slave_fault();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule